// File: doc/BRIEF.md
# Dual-Enable Launch-on-Capture Scan Sequencer

This block runs one launch-on-capture transition delay test across two short scan chains, each of which has its own scan enable. After a start request it shifts an initialization pattern into both chains with both enables high. It then applies exactly one launch clock and one capture clock. It finishes by shifting the captured response out, and while it does so the bits presented on the serial inputs are shifted in.

During the launch and capture cycles each chain follows its own mode bit. A chain told to hold keeps its enable high and goes on shifting from its serial input. A chain told to capture drops its enable and loads the outputs of a stand-in combinational core. The enables therefore differ while the test runs at speed, although neither one ever changes between launch and capture. This lets one chain carry a launch value out of the shift path while the other captures the fault effect.

The core inputs held constant during the test come from a programmable value, which is sampled together with the mode bits when the test is accepted. A clock-enable output marks the cycles in which the chains are clocked.

Top module: `scan_loc_seq`

## Requirements
- R1: After reset, busy, done and scan_clk_en are 0, sen_a and sen_b are 1, and both chains hold all zeros.
- R2: A start seen while the block is idle raises busy on the next cycle. busy then stays high for CHAIN_LEN load cycles, one launch cycle, one capture cycle and CHAIN_LEN unload cycles. In the following cycle done is 1 for exactly one cycle with busy low.
- R3: In load and unload cycles both enables are 1 and each chain shifts. Stage 0 takes the serial input, stage i takes stage i-1, and the serial output is the last stage. A pattern p loaded with bit p[CHAIN_LEN-1] first leaves stage i holding p[i].
- R4: In launch and capture, mode_hold[0] sets chain A and mode_hold[1] sets chain B. A value of 1 keeps that chain's enable at 1 and the chain shifts from its serial input. A value of 0 drives the enable to 0 and the chain loads the core outputs.
- R5: Each enable has the same value in the capture cycle as in the launch cycle. Enables change only on the boundaries between shift and launch and between capture and shift.
- R6: The core output for chain A at stage i is b[i] XOR a[(i+1) mod CHAIN_LEN]. The core output for chain B at stage i is a[i] OR pi[i mod PI_W]. Here a and b are the current chain contents and pi is the sampled constant.
- R7: mode_hold and pi_val are sampled only on the accepted start, so changing them during a test has no effect on the unloaded response.
- R8: A start asserted while busy is ignored: the running test keeps its length and produces a single done.
- R9: scan_clk_en is 1 exactly while busy. While it is 0 the chains do not change, so the serial outputs stay constant.
- R10: After done, each chain holds the bits driven on its serial input during unload. The serial output shows the bit driven in the first unload cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one test; honoured only when idle |
| mode_hold | input | 2 | Per-chain launch/capture mode, bit 0 chain A, bit 1 chain B (1 = keep shifting) |
| pi_val | input | PI_W | Constant for the core's primary inputs |
| si_a | input | 1 | Serial input of chain A |
| si_b | input | 1 | Serial input of chain B |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle completion pulse |
| sen_a | output | 1 | Scan enable of chain A |
| sen_b | output | 1 | Scan enable of chain B |
| scan_clk_en | output | 1 | Test clock gate for the chains |
| so_a | output | 1 | Serial output of chain A |
| so_b | output | 1 | Serial output of chain B |

## Verification
The tests use all four mode combinations. With both chains capturing, the cross-coupled core function is exposed in both chains. With one chain capturing and one holding, a shifted launch value is distinguished from a functional one. With both holding, the captured bits are plain shifted serial data, which confirms that the core is bypassed. The primary-input constant is varied so that the OR terms of chain B can be told apart from the chain data. One test changes the mode and the constant in mid-test and pulses start during the load phase, to show that the sampled settings and the test length are unaffected.

// File: rtl/scan_loc_pkg.sv
package scan_loc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LAUNCH,
        ST_CAPT,
        ST_UNLOAD,
        ST_DONE
    } seq_state_e;
endpackage

// File: rtl/scan_chain.sv
module scan_chain #(
    parameter int LEN = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clk_en,
    input  logic           sen,
    input  logic           si,
    input  logic [LEN-1:0] func,
    output logic [LEN-1:0] q,
    output logic           so
);
    logic [LEN-1:0] ff_d, ff_q;

    always_comb begin
        ff_d = ff_q;
        if (clk_en) begin
            if (sen) begin
                ff_d[0] = si;
                for (int i = 1; i < LEN; i++) ff_d[i] = ff_q[i-1];
            end else begin
                ff_d = func;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= ff_d;
    end

    assign q  = ff_q;
    assign so = ff_q[LEN-1];
endmodule

// File: rtl/loc_core.sv
module loc_core #(
    parameter int LEN  = 3,
    parameter int PI_W = 2
) (
    input  logic [LEN-1:0]  qa,
    input  logic [LEN-1:0]  qb,
    input  logic [PI_W-1:0] pi,
    output logic [LEN-1:0]  fa,
    output logic [LEN-1:0]  fb
);
    for (genvar i = 0; i < LEN; i++) begin : g_cell
        localparam int NXT = (i + 1) % LEN;
        localparam int PIX = i % PI_W;
        assign fa[i] = qb[i] ^ qa[NXT];
        assign fb[i] = qa[i] | pi[PIX];
    end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import scan_loc_pkg::*;
#(
    parameter int LEN  = 3,
    parameter int PI_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      mode_hold,
    input  logic [PI_W-1:0] pi_val,
    output logic            busy,
    output logic            done,
    output logic            sen_a,
    output logic            sen_b,
    output logic            lc_phase,
    output logic            capt_phase,
    output logic [PI_W-1:0] pi_q
);
    localparam int CW = $clog2(LEN) + 1;
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    typedef struct packed {
        seq_state_e      state;
        logic [CW-1:0]   cnt;
        logic [1:0]      mode;
        logic [PI_W-1:0] pi;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            ST_IDLE: if (start) begin
                st_d.state = ST_LOAD;
                st_d.cnt   = '0;
                st_d.mode  = mode_hold;
                st_d.pi    = pi_val;
            end
            ST_LOAD: begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == LAST) begin
                    st_d.state = ST_LAUNCH;
                    st_d.cnt   = '0;
                end
            end
            ST_LAUNCH: st_d.state = ST_CAPT;
            ST_CAPT:   st_d.state = ST_UNLOAD;
            ST_UNLOAD: begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == LAST) begin
                    st_d.state = ST_DONE;
                    st_d.cnt   = '0;
                end
            end
            ST_DONE:   st_d.state = ST_IDLE;
            default:   st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: ST_IDLE, cnt: '0, mode: '0, pi: '0};
        else        st_q <= st_d;
    end

    assign lc_phase   = (st_q.state == ST_LAUNCH) || (st_q.state == ST_CAPT);
    assign capt_phase = (st_q.state == ST_CAPT);
    assign busy       = (st_q.state == ST_LOAD) || lc_phase || (st_q.state == ST_UNLOAD);
    assign done       = (st_q.state == ST_DONE);
    assign sen_a      = lc_phase ? st_q.mode[0] : 1'b1;
    assign sen_b      = lc_phase ? st_q.mode[1] : 1'b1;
    assign pi_q       = st_q.pi;
endmodule

// File: rtl/scan_loc_seq.sv
module scan_loc_seq #(
    parameter int CHAIN_LEN = 3,
    parameter int PI_W      = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      mode_hold,
    input  logic [PI_W-1:0] pi_val,
    input  logic            si_a,
    input  logic            si_b,
    output logic            busy,
    output logic            done,
    output logic            sen_a,
    output logic            sen_b,
    output logic            scan_clk_en,
    output logic            so_a,
    output logic            so_b
);
    logic                 lc_phase, capt_phase;
    logic [PI_W-1:0]      pi_q;
    logic [CHAIN_LEN-1:0] qa, qb, fa, fb;

    seq_ctrl #(.LEN(CHAIN_LEN), .PI_W(PI_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_hold(mode_hold),
        .pi_val(pi_val), .busy(busy), .done(done), .sen_a(sen_a),
        .sen_b(sen_b), .lc_phase(lc_phase), .capt_phase(capt_phase),
        .pi_q(pi_q)
    );

    assign scan_clk_en = busy;

    loc_core #(.LEN(CHAIN_LEN), .PI_W(PI_W)) u_core (
        .qa(qa), .qb(qb), .pi(pi_q), .fa(fa), .fb(fb)
    );

    scan_chain #(.LEN(CHAIN_LEN)) u_chain_a (
        .clk(clk), .rst_n(rst_n), .clk_en(scan_clk_en), .sen(sen_a),
        .si(si_a), .func(fa), .q(qa), .so(so_a)
    );

    scan_chain #(.LEN(CHAIN_LEN)) u_chain_b (
        .clk(clk), .rst_n(rst_n), .clk_en(scan_clk_en), .sen(sen_b),
        .si(si_b), .func(fb), .q(qb), .so(so_b)
    );
endmodule

// File: rtl/scan_loc_chk.sv
module scan_loc_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic sen_a,
    input logic sen_b,
    input logic scan_clk_en,
    input logic so_a,
    input logic so_b,
    input logic in_lc,
    input logic in_capt
);
    a_r2_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> busy);

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r3_shift_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !in_lc) |-> (sen_a && sen_b));

    a_r5_enables_steady: assert property (@(posedge clk) disable iff (!rst_n)
        in_capt |-> (sen_a == $past(sen_a) && sen_b == $past(sen_b)));

    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_clk_en |=> $stable({so_a, so_b}));
endmodule

bind scan_loc_seq scan_loc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .sen_a(sen_a), .sen_b(sen_b), .scan_clk_en(scan_clk_en),
    .so_a(so_a), .so_b(so_b), .in_lc(lc_phase), .in_capt(capt_phase)
);

// File: tb/tb_scan_loc_seq.sv
module tb_scan_loc_seq;
    localparam int L    = 3;
    localparam int PI_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] mode_hold = '0;
    logic [PI_W-1:0] pi_val = '0;
    logic si_a = 1'b0, si_b = 1'b0;
    logic busy, done, sen_a, sen_b, scan_clk_en, so_a, so_b;

    int checks = 0;
    int fails  = 0;
    logic [1:0] md_exp = 2'b00;
    logic [1:0] exp_q[$];
    bit finished = 0;

    always #4 clk = ~clk;

    scan_loc_seq #(.CHAIN_LEN(L), .PI_W(PI_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_hold(mode_hold),
        .pi_val(pi_val), .si_a(si_a), .si_b(si_b), .busy(busy), .done(done),
        .sen_a(sen_a), .sen_b(sen_b), .scan_clk_en(scan_clk_en),
        .so_a(so_a), .so_b(so_b)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference launch/capture step (R4, R6)
    function automatic logic [2*L-1:0] lc_step(input logic [L-1:0] a, input logic [L-1:0] b,
                                               input logic [1:0] md, input logic [PI_W-1:0] pv,
                                               input logic sa, input logic sb);
        logic [L-1:0] fa, fb, na, nb;
        for (int i = 0; i < L; i++) begin
            fa[i] = b[i] ^ a[(i + 1) % L];
            fb[i] = a[i] | pv[i % PI_W];
        end
        na = md[0] ? {a[L-2:0], sa} : fa;
        nb = md[1] ? {b[L-2:0], sb} : fb;
        return {na, nb};
    endfunction

    // Monitor: tracks the busy window at the ports and compares unloaded bits
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            if (rst_n && busy) begin
                if (ph == L || ph == L + 1)
                    check("R4/R5 sen in launch/capture", {6'd0, sen_a, sen_b}, {6'd0, md_exp[0], md_exp[1]});
                else
                    check("R3 sen in shift", {6'd0, sen_a, sen_b}, 8'd3);
                if (ph >= L + 2) begin
                    if (exp_q.size() == 0) begin
                        check("R2 unload longer than expected", 8'd1, 8'd0);
                    end else begin
                        logic [1:0] e;
                        e = exp_q.pop_front();
                        check("R3/R4/R6 unloaded bits", {6'd0, so_a, so_b}, {6'd0, e});
                    end
                end
                ph++;
            end else begin
                ph = 0;
            end
        end
    end

    // Driver: computes the expected response, pushes it, then runs the test
    task automatic run_test(input logic [L-1:0] pa, input logic [L-1:0] pb,
                            input logic [1:0] md, input logic [PI_W-1:0] pv,
                            input logic [1:0] lsa, input logic [1:0] lsb,
                            input logic [L-1:0] ua, input logic [L-1:0] ub,
                            input bit disturb);
        logic [L-1:0] a, b;
        logic [2*L-1:0] r;
        logic so_hold_a, so_hold_b;
        a = pa; b = pb;
        r = lc_step(a, b, md, pv, lsa[0], lsb[0]); a = r[2*L-1:L]; b = r[L-1:0];
        r = lc_step(a, b, md, pv, lsa[1], lsb[1]); a = r[2*L-1:L]; b = r[L-1:0];
        for (int k = 0; k < L; k++) exp_q.push_back({a[L-1-k], b[L-1-k]});
        md_exp = md;

        @(posedge clk); #2;
        mode_hold = md; pi_val = pv; start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
        check("R2 busy after start", {7'd0, busy}, 8'd1);
        if (disturb) begin            // R7: settings change mid-test
            mode_hold = ~md; pi_val = ~pv;
        end
        for (int j = 0; j < L; j++) begin
            si_a = pa[L-1-j]; si_b = pb[L-1-j];
            start = disturb && (j == 1);   // R8: start while busy
            @(posedge clk); #2;
        end
        start = 1'b0;
        si_a = lsa[0]; si_b = lsb[0];
        @(posedge clk); #2;
        si_a = lsa[1]; si_b = lsb[1];
        @(posedge clk); #2;
        for (int k = 0; k < L; k++) begin
            si_a = ua[k]; si_b = ub[k];
            @(posedge clk); #2;
        end
        check("R2 done pulse", {6'd0, done, busy}, 8'd2);
        check("R10 so after unload", {6'd0, so_a, so_b}, {6'd0, ua[0], ub[0]});
        check("R2 queue drained", 8'(exp_q.size()), 8'd0);
        exp_q.delete();
        so_hold_a = so_a; so_hold_b = so_b;
        si_a = ~si_a; si_b = ~si_b;
        @(posedge clk); #2;
        check("R2 done single cycle", {6'd0, done, busy}, 8'd0);
        @(posedge clk); #2;
        check("R9 chains frozen while idle", {5'd0, scan_clk_en, so_a, so_b},
              {5'd0, 1'b0, so_hold_a, so_hold_b});
        mode_hold = '0; pi_val = '0;
    endtask

    initial begin
        #3;
        check("R1 reset outputs", {3'd0, busy, done, scan_clk_en, sen_a, sen_b}, 8'b0000_0011);
        check("R1 reset chains", {6'd0, so_a, so_b}, 8'd0);
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R4/R6: both chains capture
        run_test(3'b101, 3'b011, 2'b00, 2'b00, 2'b10, 2'b01, 3'b110, 3'b001, 0);
        // R4: chain A holds, chain B captures
        run_test(3'b110, 3'b100, 2'b01, 2'b01, 2'b01, 2'b11, 3'b011, 3'b101, 0);
        // R4: chain B holds, chain A captures
        run_test(3'b011, 3'b111, 2'b10, 2'b10, 2'b11, 2'b00, 3'b100, 3'b010, 0);
        // R4: both hold, core bypassed
        run_test(3'b001, 3'b010, 2'b11, 2'b11, 2'b10, 2'b01, 3'b111, 3'b000, 0);
        // R6: OR terms with a set constant
        run_test(3'b000, 3'b000, 2'b00, 2'b11, 2'b00, 2'b00, 3'b101, 3'b110, 0);
        // R7/R8: mid-test changes and start while busy
        run_test(3'b100, 3'b001, 2'b01, 2'b10, 2'b01, 2'b10, 3'b010, 3'b111, 1);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule